// File: doc/BRIEF.md
# Four-Buffer Converter Result Sequencer

This controller drives an external analog-to-digital converter core in a repeating single-channel mode. Once enabled, it converts the selected input channel over and over. Each result goes into the next of four slots in a bank of result registers. Channels 0 to 3 use the lower bank (registers 0 to 3) and channels 4 to 7 use the upper bank (registers 4 to 7).

Every fourth completed conversion closes a sequence. At that point the block raises a one-cycle interrupt and starts the next sequence on its own, with no re-arming. It runs until software clears the enable input.

Results that have not been read are overwritten by later sequences; nothing protects or holds them. The channel select is captured only when a sequence begins.

Toward the converter, the block issues a one-cycle start strobe together with the channel number. It then waits for a done strobe that carries the result byte.

Top module: `adc_quad_seq`

## Requirements
- R1: While reset is asserted and right after it, `conv_start_o` and `irq_o` are 0 and all eight result registers read 0.
- R2: Each conversion request is a `conv_start_o` pulse exactly one clock long. The next request comes no earlier than the clock after the converter's done strobe.
- R3: With a channel from 0 to 3 selected, the k-th result of a sequence (k = 0..3) is written to result register k. Register i occupies bits [8i+7:8i] of `results_o`, and registers 4 to 7 are left untouched.
- R4: With a channel from 4 to 7 selected, the k-th result of a sequence is written to result register 4+k.
- R5: `irq_o` is a single-cycle pulse that is high in the clock after the done strobe of the fourth conversion of a sequence. It stays low after the first three conversions.
- R6: In the same clock as the interrupt pulse, a new start is issued without any change to enable, and the next result goes to the first slot of the bank.
- R7: When `enable_i` is 0, no new start is issued. A conversion already in flight still has its result written to its slot, but it never produces an interrupt. The next time the block is enabled, it starts again at the first slot.
- R8: `chan_sel_i` is sampled only when a sequence begins. A change in the middle of a sequence alters neither `conv_chan_o` nor the target bank until the next sequence.
- R9: A later sequence overwrites earlier results in the same slots without any hold or overrun protection.
- R10: `conv_chan_o` presents the channel of the current sequence for as long as its conversions run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; 0 stops further conversions |
| chan_sel_i | input | 3 | Channel to convert, sampled at sequence start |
| conv_start_o | output | 1 | One-cycle conversion request to the converter |
| conv_chan_o | output | 3 | Channel presented to the converter |
| conv_done_i | input | 1 | Converter done strobe, one cycle |
| conv_data_i | input | 8 | Result byte, valid with the done strobe |
| results_o | output | 64 | Eight result registers, register i at bits [8i+7:8i] |
| irq_o | output | 1 | End-of-sequence interrupt pulse |

## Verification
The bench targets the wrap from the fourth slot back to the first. A design that is off by one there would raise the interrupt after the third or fifth result, or would write the fifth result into a missing slot instead of overwriting register 0.

It also clears enable while a conversion is in flight. A design that gets this wrong would either drop the late result, count it toward an interrupt, keep issuing starts, or resume at the old slot after re-enable.

Finally, it changes the channel select mid-sequence. A design that samples the select continuously would switch `conv_chan_o` or the bank before the sequence boundary.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int SLOTS = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [CH_W-1:0]   chan_sel_i,
  input  logic              conv_done_i,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              wr_en_o,
  output logic [CH_W-1:0]   wr_addr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              seq_end_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic              abandon_q, abandon_d;
  logic              irq_q, irq_d;
  logic              wr_en;

  // Next-state logic: issue start, wait for done, advance the slot ring.
  always_comb begin
    state_d   = state_q;
    slot_d    = slot_q;
    ch_d      = ch_q;
    abandon_d = abandon_q;
    irq_d     = 1'b0;
    wr_en     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        slot_d    = '0;
        abandon_d = 1'b0;
        if (enable_i) begin
          state_d = ST_START;
          ch_d    = chan_sel_i;
        end
      end
      ST_START: begin
        state_d   = ST_WAIT;
        abandon_d = !enable_i;
      end
      ST_WAIT: begin
        if (!enable_i) abandon_d = 1'b1;
        if (conv_done_i) begin
          wr_en = 1'b1;
          if (abandon_q || !enable_i) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_START;
            if (slot_q == LAST_SLOT) begin
              slot_d = '0;
              irq_d  = 1'b1;
              ch_d   = chan_sel_i;
            end else begin
              slot_d = slot_q + 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      slot_q    <= '0;
      ch_q      <= '0;
      abandon_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      slot_q    <= slot_d;
      ch_q      <= ch_d;
      abandon_q <= abandon_d;
      irq_q     <= irq_d;
    end
  end

  assign conv_start_o = (state_q == ST_START);
  assign chan_o       = ch_q;
  assign wr_en_o      = wr_en;
  assign wr_addr_o    = {ch_q[CH_W-1:SLOT_W], slot_q};
  assign slot_o       = slot_q;
  assign seq_end_o    = irq_q;

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [NREG*DATA_W-1:0] regs_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    logic              ce;

    assign ce = wr_en_i && (wr_addr_i == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (ce) val_q <= wr_data_i;
    end

    assign regs_o[i*DATA_W +: DATA_W] = val_q;
  end

endmodule

// File: rtl/adc_quad_seq.sv
module adc_quad_seq #(
  parameter int DATA_W = 8,
  parameter int CH_W   = 3,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int NREG   = 1 << CH_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable_i,
  input  logic [CH_W-1:0]        chan_sel_i,
  output logic                   conv_start_o,
  output logic [CH_W-1:0]        conv_chan_o,
  input  logic                   conv_done_i,
  input  logic [DATA_W-1:0]      conv_data_i,
  output logic [NREG*DATA_W-1:0] results_o,
  output logic                   irq_o
);

  logic              wr_en_w;
  logic [CH_W-1:0]   wr_addr_w;
  logic [SLOT_W-1:0] slot_w;

  adc_seq_ctrl #(
    .CH_W  (CH_W),
    .SLOTS (SLOTS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .chan_sel_i   (chan_sel_i),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .chan_o       (conv_chan_o),
    .wr_en_o      (wr_en_w),
    .wr_addr_o    (wr_addr_w),
    .slot_o       (slot_w),
    .seq_end_o    (irq_o)
  );

  adc_result_bank #(
    .DATA_W (DATA_W),
    .ADDR_W (CH_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_w),
    .wr_addr_i (wr_addr_w),
    .wr_data_i (conv_data_i),
    .regs_o    (results_o)
  );

endmodule

// File: rtl/adc_quad_seq_chk.sv
module adc_quad_seq_chk #(
  parameter int CH_W   = 3,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic              conv_start_o,
  input logic [CH_W-1:0]   conv_chan_o,
  input logic              conv_done_i,
  input logic              irq_o,
  input logic [SLOT_W-1:0] slot_i
);

  localparam logic [SLOT_W-1:0] LAST = {SLOT_W{1'b1}};

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  assert_start_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> $past(enable_i));

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_irq_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(conv_done_i) && $past(slot_i) == LAST));

  assert_irq_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (conv_start_o && slot_i == '0));

  assert_chan_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> $stable(conv_chan_o));

endmodule

bind adc_quad_seq adc_quad_seq_chk #(
  .CH_W   (CH_W),
  .SLOT_W (SLOT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable_i     (enable_i),
  .conv_start_o (conv_start_o),
  .conv_chan_o  (conv_chan_o),
  .conv_done_i  (conv_done_i),
  .irq_o        (irq_o),
  .slot_i       (slot_w)
);

// File: tb/tb_adc_quad_seq.sv
`timescale 1ns/1ps
module tb_adc_quad_seq;

  logic        clk;
  logic        rst_n;
  logic        enable_i;
  logic [2:0]  chan_sel_i;
  logic        conv_start_o;
  logic [2:0]  conv_chan_o;
  logic        conv_done_i;
  logic [7:0]  conv_data_i;
  logic [63:0] results_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;

  adc_quad_seq dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .chan_sel_i   (chan_sel_i),
    .conv_start_o (conv_start_o),
    .conv_chan_o  (conv_chan_o),
    .conv_done_i  (conv_done_i),
    .conv_data_i  (conv_data_i),
    .results_o    (results_o),
    .irq_o        (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (rst_n && irq_o) irq_cnt++;
  end

  function automatic int rreg(input int i);
    return int'(results_o[i*8 +: 8]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Converter model: wait for a start, answer with done and data one clock later.
  task automatic serve(input logic [7:0] d);
    int n = 0;
    while (!conv_start_o && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(conv_start_o == 1'b1, "R2", "start seen", int'(conv_start_o), 1);
    @(negedge clk);
    check(conv_start_o == 1'b0, "R2", "start one cycle", int'(conv_start_o), 0);
    conv_done_i = 1'b1;
    conv_data_i = d;
    @(negedge clk);
    conv_done_i = 1'b0;
  endtask

  // Stop the block while a start is showing and absorb the in-flight conversion.
  task automatic drain();
    enable_i = 1'b0;
    @(negedge clk);
    conv_done_i = 1'b1;
    conv_data_i = 8'h00;
    @(negedge clk);
    conv_done_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    enable_i = 1'b0;
    chan_sel_i = '0;
    conv_done_i = 1'b0;
    conv_data_i = '0;
    repeat (3) @(negedge clk);
    check(conv_start_o == 1'b0, "R1", "start in reset", int'(conv_start_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(conv_start_o == 1'b0, "R1", "start after reset", int'(conv_start_o), 0);
    check(irq_o == 1'b0, "R1", "irq after reset", int'(irq_o), 0);
    for (int i = 0; i < 8; i++)
      check(rreg(i) == 0, "R1", $sformatf("reg%0d after reset", i), rreg(i), 0);
  endtask

  task automatic t_low_bank();
    int c0 = irq_cnt;
    chan_sel_i = 3'd2;
    enable_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      serve(8'hA0 + 8'(k));
      check(rreg(k) == 'hA0 + k, "R3", $sformatf("low slot %0d", k), rreg(k), 'hA0 + k);
      check(conv_chan_o == 3'd2, "R10", "channel shown", int'(conv_chan_o), 2);
      if (k < 3) check(irq_o == 1'b0, "R5", "no irq early", int'(irq_o), 0);
    end
    check(irq_o == 1'b1, "R5", "irq after fourth", int'(irq_o), 1);
    check(conv_start_o == 1'b1, "R6", "auto restart", int'(conv_start_o), 1);
    check(rreg(4) == 0, "R3", "upper bank untouched", rreg(4), 0);
    serve(8'hB0);
    check(rreg(0) == 'hB0, "R9", "slot 0 overwritten", rreg(0), 'hB0);
    check(rreg(1) == 'hA1, "R6", "slot 1 kept", rreg(1), 'hA1);
    check(irq_cnt - c0 == 1, "R5", "one irq pulse", irq_cnt - c0, 1);
  endtask

  task automatic t_stop();
    int c0 = irq_cnt;
    bit seen = 1'b0;
    enable_i = 1'b0;
    @(negedge clk);
    conv_done_i = 1'b1;
    conv_data_i = 8'h5A;
    @(negedge clk);
    conv_done_i = 1'b0;
    check(rreg(1) == 'h5A, "R7", "in-flight result kept", rreg(1), 'h5A);
    check(irq_o == 1'b0, "R7", "no irq on stop", int'(irq_o), 0);
    repeat (8) begin
      @(negedge clk);
      if (conv_start_o) seen = 1'b1;
    end
    check(seen == 1'b0, "R7", "no start while disabled", int'(seen), 0);
    check(irq_cnt == c0, "R7", "irq count on stop", irq_cnt - c0, 0);
    enable_i = 1'b1;
    serve(8'hC3);
    check(rreg(0) == 'hC3, "R7", "restart at slot 0", rreg(0), 'hC3);
    check(rreg(2) == 'hA2, "R7", "slot 2 kept", rreg(2), 'hA2);
    drain();
  endtask

  task automatic t_high_bank();
    int c0 = irq_cnt;
    chan_sel_i = 3'd6;
    enable_i = 1'b1;
    serve(8'hD0);
    check(rreg(4) == 'hD0, "R4", "high slot 0", rreg(4), 'hD0);
    check(conv_chan_o == 3'd6, "R10", "channel 6 shown", int'(conv_chan_o), 6);
    chan_sel_i = 3'd1;
    for (int k = 1; k < 4; k++) begin
      check(conv_chan_o == 3'd6, "R8", "channel held mid-sequence", int'(conv_chan_o), 6);
      serve(8'hD0 + 8'(k));
      check(rreg(4 + k) == 'hD0 + k, "R4", $sformatf("high slot %0d", k), rreg(4 + k), 'hD0 + k);
    end
    check(irq_o == 1'b1, "R5", "irq after fourth high", int'(irq_o), 1);
    check(conv_chan_o == 3'd1, "R8", "new channel at boundary", int'(conv_chan_o), 1);
    serve(8'hE0);
    check(rreg(0) == 'hE0, "R8", "new bank used", rreg(0), 'hE0);
    check(rreg(4) == 'hD0, "R8", "old bank kept", rreg(4), 'hD0);
    drain();
    check(irq_cnt - c0 == 1, "R5", "one irq high bank", irq_cnt - c0, 1);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_low_bank();
    t_stop();
    t_high_bank();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule